// File: doc/BRIEF.md
# Quantized Diagonal Mixture Scorer

This block scores one acoustic observation against a Gaussian mixture with diagonal covariance, working in the log domain. The model reaches it in compressed form. For every dimension a component record gives a short index that selects a mean and a short index that selects an inverse variance. Each index is looked up in a small table that belongs to that dimension alone. The tables and the observation vector are written through plain write ports before scoring begins.

A component record is accepted with a valid/ready handshake. The record carries a weight term that already contains every normalisation constant, together with the packed indices for all dimensions and two flags that mark the first and the last component of a mixture. The datapath works through two dimensions per clock with two identical arithmetic lanes. Each lane multiplies the squared distance by the inverse variance and subtracts the result from the running component score. When a component is finished it is folded into the mixture total with a binary log-add. The larger operand is corrected by a value read from a loadable table that is indexed by the gap between the two operands. When the last component has been folded, the mixture log-likelihood appears on the output for one cycle.

Top module: `qgmm_scorer`

## Requirements
- R1: After reset, `comp_ready` is high and `out_valid` is low.
- R2: Table writes are selected by `tbl_wr_kind`: 0 writes the mean entry (`tbl_wr_dim`, index `tbl_wr_addr[4:0]`), 1 writes the inverse-variance entry (`tbl_wr_dim`, index `tbl_wr_addr[2:0]`), 2 writes log-add correction entry `tbl_wr_addr[7:0]`, and 3 writes nothing. The observation of a dimension is written through `feat_wr_*`. Dimension d uses the mean index at `comp_mean_idx[5d+4:5d]` and the inverse-variance index at `comp_ivar_idx[3d+2:3d]`.
- R3: The cost of one dimension is floor((x − μ)² · v / 65536), limited to 2^31 − 1. Here x and μ are signed 16-bit values and v is an unsigned 16-bit value.
- R4: A component score equals its signed 32-bit weight minus the sum of the 39 dimension costs, held at −2^31 if it would go lower.
- R5: A record is taken when `comp_valid` and `comp_ready` are both high at a clock edge. `comp_ready` then stays low for exactly 21 cycles.
- R6: Folding two scores gives the larger score plus the correction entry indexed by their difference when that difference is below 256. The sum is held at 2^31 − 1 if it would go higher.
- R7: When the two scores differ by 256 or more, the fold returns the larger score unchanged.
- R8: A record with the first flag starts a new mixture from its own score alone and discards any earlier partial total.
- R9: A record with the last flag raises `out_valid` for one cycle, 21 clock edges after its acceptance edge, with the mixture total on `out_score`. No other record raises `out_valid`.
- R10: A `comp_valid` raised while `comp_ready` is low is ignored. It does not change the result in progress and it produces no extra output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_kind | input | 2 | Table select: 0 mean, 1 inverse variance, 2 correction, 3 none |
| tbl_wr_dim | input | 6 | Dimension of a mean or inverse-variance write |
| tbl_wr_addr | input | 8 | Entry index within the selected table |
| tbl_wr_data | input | 16 | Entry value |
| feat_wr_en | input | 1 | Observation write strobe |
| feat_wr_dim | input | 6 | Observation dimension |
| feat_wr_data | input | 16 | Observation value, signed |
| comp_valid | input | 1 | Component record offered |
| comp_ready | output | 1 | Scorer can take a record |
| comp_first | input | 1 | Record opens a mixture |
| comp_last | input | 1 | Record closes a mixture |
| comp_weight | input | 32 | Signed weight term of the component |
| comp_mean_idx | input | 195 | Packed 5-bit mean indices, dimension 0 in the low bits |
| comp_ivar_idx | input | 117 | Packed 3-bit inverse-variance indices, dimension 0 in the low bits |
| out_valid | output | 1 | Mixture result strobe |
| out_score | output | 32 | Signed mixture log-likelihood |

## Verification
A record accepted at edge E0 spends edges E1 through E20 in the lane beats. It is folded at edge E21. At that same edge `comp_ready` returns high and, for a closing record, `out_valid` and `out_score` update. The bench drives every input at a falling edge. After each acceptance it counts 21 rising edges and samples at the falling edge that follows each one. Every earlier sample must show ready low and valid low. The sample after E21 must show ready high, the valid level set by the last flag, and the computed score. Ignored-input cases are checked through that same output window and through the window that follows it.

// File: rtl/qgmm_pkg.sv
package qgmm_pkg;

  localparam int QG_DIMS       = 39;
  localparam int QG_FEAT_W     = 16;
  localparam int QG_TAB_W      = 16;
  localparam int QG_MEAN_IW    = 5;
  localparam int QG_IVAR_IW    = 3;
  localparam int QG_ACC_W      = 32;
  localparam int QG_LA_DEPTH   = 256;
  localparam int QG_LANES      = 2;
  localparam int QG_PROD_SHIFT = 16;

  typedef enum logic [1:0] {
    TK_MEAN = 2'd0,
    TK_IVAR = 2'd1,
    TK_CORR = 2'd2,
    TK_NONE = 2'd3
  } tbl_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT  = 2'd1,
    ST_MERGE = 2'd2
  } scorer_state_e;

  // largest and smallest value of a signed accumulator of width w
  function automatic longint acc_max(int w);
    return (longint'(1) <<< (w - 1)) - 1;
  endfunction

  function automatic longint acc_min(int w);
    return -(longint'(1) <<< (w - 1));
  endfunction

  // cost of one dimension: scaled weighted squared distance, capped
  function automatic longint dim_term(longint x, longint m, longint iv,
                                      int shift, longint cap);
    longint d;
    longint p;
    d = x - m;
    p = (d * d * iv) >>> shift;
    return (p > cap) ? cap : p;
  endfunction

  // subtract a non-negative cost, never dropping below floor_v
  function automatic longint sat_sub_floor(longint a, longint t, longint floor_v);
    longint r;
    r = a - t;
    return (r < floor_v) ? floor_v : r;
  endfunction

  // add a non-negative correction, never rising above ceil_v
  function automatic longint sat_add_ceil(longint a, longint c, longint ceil_v);
    longint r;
    r = a + c;
    return (r > ceil_v) ? ceil_v : r;
  endfunction

endpackage

// File: rtl/qgmm_tables.sv
module qgmm_tables
  import qgmm_pkg::*;
#(
  parameter int DIMS    = QG_DIMS,
  parameter int FEAT_W  = QG_FEAT_W,
  parameter int TAB_W   = QG_TAB_W,
  parameter int MEAN_IW = QG_MEAN_IW,
  parameter int IVAR_IW = QG_IVAR_IW,
  parameter int LANES   = QG_LANES,
  parameter int DIM_W   = $clog2(DIMS)
) (
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [1:0]                        wr_kind,
  input  logic [DIM_W-1:0]                  wr_dim,
  input  logic [MEAN_IW-1:0]                wr_idx,
  input  logic [TAB_W-1:0]                  wr_data,
  input  logic                              feat_wr_en,
  input  logic [DIM_W-1:0]                  feat_wr_dim,
  input  logic [FEAT_W-1:0]                 feat_wr_data,
  input  logic [LANES-1:0][DIM_W-1:0]       rd_dim,
  input  logic [LANES-1:0][MEAN_IW-1:0]     rd_mean_idx,
  input  logic [LANES-1:0][IVAR_IW-1:0]     rd_ivar_idx,
  output logic [LANES-1:0][FEAT_W-1:0]      rd_feat,
  output logic [LANES-1:0][TAB_W-1:0]       rd_mean,
  output logic [LANES-1:0][TAB_W-1:0]       rd_ivar
);

  localparam int MEAN_AW    = DIM_W + MEAN_IW;
  localparam int IVAR_AW    = DIM_W + IVAR_IW;
  localparam int MEAN_DEPTH = DIMS << MEAN_IW;
  localparam int IVAR_DEPTH = DIMS << IVAR_IW;

  logic [TAB_W-1:0]  mean_mem [MEAN_DEPTH];
  logic [TAB_W-1:0]  ivar_mem [IVAR_DEPTH];
  logic [FEAT_W-1:0] feat_mem [DIMS];

  logic dim_ok, feat_dim_ok;
  assign dim_ok      = wr_dim < DIM_W'(DIMS);
  assign feat_dim_ok = feat_wr_dim < DIM_W'(DIMS);

  always_ff @(posedge clk) begin
    if (wr_en && dim_ok) begin
      case (wr_kind)
        TK_MEAN: mean_mem[MEAN_AW'({wr_dim, wr_idx})] <= wr_data;
        TK_IVAR: ivar_mem[IVAR_AW'({wr_dim, wr_idx[IVAR_IW-1:0]})] <= wr_data;
        default: ;
      endcase
    end
    if (feat_wr_en && feat_dim_ok) begin
      feat_mem[feat_wr_dim] <= feat_wr_data;
    end
  end

  // one read port per lane on every table
  for (genvar l = 0; l < LANES; l++) begin : g_port
    assign rd_feat[l] = feat_mem[rd_dim[l]];
    assign rd_mean[l] = mean_mem[MEAN_AW'({rd_dim[l], rd_mean_idx[l]})];
    assign rd_ivar[l] = ivar_mem[IVAR_AW'({rd_dim[l], rd_ivar_idx[l]})];
  end

endmodule

// File: rtl/qgmm_lane.sv
module qgmm_lane
  import qgmm_pkg::*;
#(
  parameter int FEAT_W     = QG_FEAT_W,
  parameter int TAB_W      = QG_TAB_W,
  parameter int ACC_W      = QG_ACC_W,
  parameter int PROD_SHIFT = QG_PROD_SHIFT
) (
  input  logic              active,
  input  logic [FEAT_W-1:0] feat,
  input  logic [TAB_W-1:0]  mean_val,
  input  logic [TAB_W-1:0]  ivar_val,
  output logic [ACC_W-1:0]  term
);

  // feature and mean are signed, the inverse variance is unsigned
  always_comb begin
    if (active) begin
      term = ACC_W'(dim_term(longint'($signed(feat)),
                             longint'($signed(mean_val)),
                             longint'(ivar_val),
                             PROD_SHIFT, acc_max(ACC_W)));
    end else begin
      term = '0;
    end
  end

endmodule

// File: rtl/qgmm_logadd.sv
module qgmm_logadd
  import qgmm_pkg::*;
#(
  parameter int ACC_W = QG_ACC_W,
  parameter int TAB_W = QG_TAB_W,
  parameter int DEPTH = QG_LA_DEPTH,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_addr,
  input  logic [TAB_W-1:0]        wr_data,
  input  logic signed [ACC_W-1:0] in_a,
  input  logic signed [ACC_W-1:0] in_b,
  output logic signed [ACC_W-1:0] out_hi,
  output logic                    out_far,
  output logic signed [ACC_W-1:0] out_sum
);

  logic [TAB_W-1:0] corr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) corr_mem[wr_addr] <= wr_data;
  end

  logic signed [ACC_W-1:0] lo;
  logic [ACC_W:0]          gap;
  logic [TAB_W-1:0]        corr;

  // order the operands so the first is not smaller
  assign out_hi  = (in_a >= in_b) ? in_a : in_b;
  assign lo      = (in_a >= in_b) ? in_b : in_a;
  assign gap     = {out_hi[ACC_W-1], out_hi} - {lo[ACC_W-1], lo};
  assign out_far = gap >= (ACC_W+1)'(DEPTH);
  assign corr    = corr_mem[gap[IW-1:0]];

  assign out_sum = out_far ? out_hi
                 : ACC_W'(sat_add_ceil(longint'(out_hi), longint'(corr), acc_max(ACC_W)));

endmodule

// File: rtl/qgmm_scorer.sv
module qgmm_scorer
  import qgmm_pkg::*;
#(
  parameter int DIMS       = QG_DIMS,
  parameter int FEAT_W     = QG_FEAT_W,
  parameter int TAB_W      = QG_TAB_W,
  parameter int MEAN_IW    = QG_MEAN_IW,
  parameter int IVAR_IW    = QG_IVAR_IW,
  parameter int ACC_W      = QG_ACC_W,
  parameter int LA_DEPTH   = QG_LA_DEPTH,
  parameter int LANES      = QG_LANES,
  parameter int PROD_SHIFT = QG_PROD_SHIFT,
  localparam int DIM_W     = $clog2(DIMS),
  localparam int LA_IW     = $clog2(LA_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tbl_wr_en,
  input  logic [1:0]                tbl_wr_kind,
  input  logic [DIM_W-1:0]          tbl_wr_dim,
  input  logic [LA_IW-1:0]          tbl_wr_addr,
  input  logic [TAB_W-1:0]          tbl_wr_data,
  input  logic                      feat_wr_en,
  input  logic [DIM_W-1:0]          feat_wr_dim,
  input  logic [FEAT_W-1:0]         feat_wr_data,
  input  logic                      comp_valid,
  output logic                      comp_ready,
  input  logic                      comp_first,
  input  logic                      comp_last,
  input  logic [ACC_W-1:0]          comp_weight,
  input  logic [DIMS*MEAN_IW-1:0]   comp_mean_idx,
  input  logic [DIMS*IVAR_IW-1:0]   comp_ivar_idx,
  output logic                      out_valid,
  output logic [ACC_W-1:0]          out_score
);

  localparam int BEATS  = (DIMS + LANES - 1) / LANES;
  localparam int BEAT_W = $clog2(BEATS);

  scorer_state_e           state_q;
  logic [BEAT_W-1:0]       beat_q;
  logic [DIMS*MEAN_IW-1:0] rec_mean;
  logic [DIMS*IVAR_IW-1:0] rec_ivar;
  logic                    rec_first, rec_last;
  logic signed [ACC_W-1:0] comp_acc;
  logic signed [ACC_W-1:0] mix_acc;
  logic                    out_valid_q;
  logic [ACC_W-1:0]        out_score_q;

  // named events for the bound checker
  logic ev_accept, ev_beat, ev_merge, ev_close, ev_fold;
  assign ev_accept = comp_valid && comp_ready;
  assign ev_beat   = state_q == ST_BEAT;
  assign ev_merge  = state_q == ST_MERGE;
  assign ev_close  = ev_merge && rec_last;
  assign ev_fold   = ev_merge && !rec_first;

  assign comp_ready = state_q == ST_IDLE;
  assign out_valid  = out_valid_q;
  assign out_score  = out_score_q;

  // ---------------- lanes: dimensions beat*LANES + l ----------------
  logic [LANES-1:0][DIM_W-1:0]   lane_dim;
  logic [LANES-1:0]              lane_active;
  logic [LANES-1:0][MEAN_IW-1:0] lane_mean_idx;
  logic [LANES-1:0][IVAR_IW-1:0] lane_ivar_idx;
  logic [LANES-1:0][FEAT_W-1:0]  lane_feat;
  logic [LANES-1:0][TAB_W-1:0]   lane_mean;
  logic [LANES-1:0][TAB_W-1:0]   lane_ivar;
  logic [LANES-1:0][ACC_W-1:0]   lane_term;
  logic signed [ACC_W-1:0]       acc_chain [LANES+1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DIM_W:0] raw_dim;
    assign raw_dim        = (DIM_W+1)'(int'(beat_q) * LANES + l);
    assign lane_active[l] = raw_dim < (DIM_W+1)'(DIMS);
    assign lane_dim[l]    = lane_active[l] ? raw_dim[DIM_W-1:0] : '0;
    assign lane_mean_idx[l] = rec_mean[int'(lane_dim[l]) * MEAN_IW +: MEAN_IW];
    assign lane_ivar_idx[l] = rec_ivar[int'(lane_dim[l]) * IVAR_IW +: IVAR_IW];

    qgmm_lane #(
      .FEAT_W(FEAT_W), .TAB_W(TAB_W), .ACC_W(ACC_W), .PROD_SHIFT(PROD_SHIFT)
    ) u_lane (
      .active  (lane_active[l]),
      .feat    (lane_feat[l]),
      .mean_val(lane_mean[l]),
      .ivar_val(lane_ivar[l]),
      .term    (lane_term[l])
    );

    assign acc_chain[l+1] = ACC_W'(sat_sub_floor(longint'(acc_chain[l]),
                                                 longint'(lane_term[l]),
                                                 acc_min(ACC_W)));
  end
  assign acc_chain[0] = comp_acc;

  qgmm_tables #(
    .DIMS(DIMS), .FEAT_W(FEAT_W), .TAB_W(TAB_W), .MEAN_IW(MEAN_IW),
    .IVAR_IW(IVAR_IW), .LANES(LANES), .DIM_W(DIM_W)
  ) u_tables (
    .clk         (clk),
    .wr_en       (tbl_wr_en),
    .wr_kind     (tbl_wr_kind),
    .wr_dim      (tbl_wr_dim),
    .wr_idx      (tbl_wr_addr[MEAN_IW-1:0]),
    .wr_data     (tbl_wr_data),
    .feat_wr_en  (feat_wr_en),
    .feat_wr_dim (feat_wr_dim),
    .feat_wr_data(feat_wr_data),
    .rd_dim      (lane_dim),
    .rd_mean_idx (lane_mean_idx),
    .rd_ivar_idx (lane_ivar_idx),
    .rd_feat     (lane_feat),
    .rd_mean     (lane_mean),
    .rd_ivar     (lane_ivar)
  );

  // ---------------- mixture fold ----------------
  logic                    la_wr_en;
  logic signed [ACC_W-1:0] la_hi, la_sum, merged;
  logic                    la_far;

  assign la_wr_en = tbl_wr_en && (tbl_wr_kind == TK_CORR);

  qgmm_logadd #(
    .ACC_W(ACC_W), .TAB_W(TAB_W), .DEPTH(LA_DEPTH), .IW(LA_IW)
  ) u_logadd (
    .clk    (clk),
    .wr_en  (la_wr_en),
    .wr_addr(tbl_wr_addr),
    .wr_data(tbl_wr_data),
    .in_a   (mix_acc),
    .in_b   (comp_acc),
    .out_hi (la_hi),
    .out_far(la_far),
    .out_sum(la_sum)
  );

  assign merged = rec_first ? comp_acc : la_sum;

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      rec_mean    <= '0;
      rec_ivar    <= '0;
      rec_first   <= 1'b0;
      rec_last    <= 1'b0;
      comp_acc    <= '0;
      mix_acc     <= '0;
      out_valid_q <= 1'b0;
      out_score_q <= '0;
    end else begin
      out_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (comp_valid) begin
            rec_mean  <= comp_mean_idx;
            rec_ivar  <= comp_ivar_idx;
            rec_first <= comp_first;
            rec_last  <= comp_last;
            comp_acc  <= comp_weight;
            beat_q    <= '0;
            state_q   <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          comp_acc <= acc_chain[LANES];
          if (beat_q == BEAT_W'(BEATS - 1)) begin
            state_q <= ST_MERGE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_MERGE: begin
          mix_acc <= merged;
          if (rec_last) begin
            out_valid_q <= 1'b1;
            out_score_q <= merged;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qgmm_scorer_sva.sv
module qgmm_scorer_sva #(
  parameter int ACC_W = 32,
  parameter int TAB_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             comp_ready,
  input logic             out_valid,
  input logic             ev_accept,
  input logic             ev_beat,
  input logic             ev_close,
  input logic             ev_fold,
  input logic [ACC_W-1:0] comp_acc,
  input logic [ACC_W-1:0] la_hi,
  input logic [ACC_W-1:0] la_sum
);

  localparam longint CORR_MAX = (longint'(1) <<< TAB_W) - 1;

  assert_ready_out_of_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (comp_ready && !out_valid));

  assert_busy_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !comp_ready);

  assert_score_never_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat |=> ($signed(comp_acc) <= $signed($past(comp_acc))));

  assert_fold_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fold |-> (($signed(la_sum) >= $signed(la_hi)) &&
                 (longint'($signed(la_sum)) - longint'($signed(la_hi)) <= CORR_MAX)));

  assert_close_raises_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> out_valid);

  assert_valid_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_valid_only_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(ev_close));

endmodule

bind qgmm_scorer qgmm_scorer_sva #(.ACC_W(ACC_W), .TAB_W(TAB_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .comp_ready(comp_ready),
  .out_valid (out_valid),
  .ev_accept (ev_accept),
  .ev_beat   (ev_beat),
  .ev_close  (ev_close),
  .ev_fold   (ev_fold),
  .comp_acc  (comp_acc),
  .la_hi     (la_hi),
  .la_sum    (la_sum)
);

// File: tb/qgmm_scorer_bench.sv
`timescale 1ns/1ps
module qgmm_scorer_bench;

  localparam int D   = 39;
  localparam int MW  = 5;
  localparam int VW  = 3;
  localparam longint AMAX = 64'sd2147483647;
  localparam longint AMIN = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_wr_en = 1'b0;
  logic [1:0] tbl_wr_kind = '0;
  logic [5:0] tbl_wr_dim = '0;
  logic [7:0] tbl_wr_addr = '0;
  logic [15:0] tbl_wr_data = '0;
  logic feat_wr_en = 1'b0;
  logic [5:0] feat_wr_dim = '0;
  logic [15:0] feat_wr_data = '0;
  logic comp_valid = 1'b0;
  logic comp_ready;
  logic comp_first = 1'b0;
  logic comp_last = 1'b0;
  logic [31:0] comp_weight = '0;
  logic [D*MW-1:0] comp_mean_idx = '0;
  logic [D*VW-1:0] comp_ivar_idx = '0;
  logic out_valid;
  logic [31:0] out_score;

  always #2.5 clk = ~clk;

  qgmm_scorer u_qgmm_scorer (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_kind(tbl_wr_kind), .tbl_wr_dim(tbl_wr_dim),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .feat_wr_en(feat_wr_en), .feat_wr_dim(feat_wr_dim), .feat_wr_data(feat_wr_data),
    .comp_valid(comp_valid), .comp_ready(comp_ready),
    .comp_first(comp_first), .comp_last(comp_last), .comp_weight(comp_weight),
    .comp_mean_idx(comp_mean_idx), .comp_ivar_idx(comp_ivar_idx),
    .out_valid(out_valid), .out_score(out_score)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // bench copies of what it wrote
  int t_feat [D];
  int t_mean [D][32];
  int t_ivar [D][8];
  int t_corr [256];
  int mi [D];
  int vi [D];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected component score: total cost first, then one clamp
  function automatic longint model_comp(longint w);
    longint total = 0;
    for (int d = 0; d < D; d++) begin
      longint diff = longint'(t_feat[d]) - longint'(t_mean[d][mi[d]]);
      longint t = (diff * diff * longint'(t_ivar[d][vi[d]])) / 65536;
      if (t > AMAX) t = AMAX;
      total += t;
    end
    total = w - total;
    return (total < AMIN) ? AMIN : total;
  endfunction

  function automatic longint model_fold(longint a, longint b);
    longint big = (a > b) ? a : b;
    longint gap = (a > b) ? a - b : b - a;
    longint r = big;
    if (gap < 256) r = big + t_corr[gap];
    return (r > AMAX) ? AMAX : r;
  endfunction

  function automatic int mean_val(int d, int i);
    if (i == 0) return t_feat[d];
    if (i == 31 && d == 0) return -32768;
    return (i - 16) * 64 + d * 3;
  endfunction

  task automatic set_pattern(input int p);
    for (int d = 0; d < D; d++) begin
      mi[d] = (p + d) % 32;
      vi[d] = (p * 3 + d) % 8;
    end
  endtask

  task automatic wr_tbl(input int kind, input int dim, input int addr, input int data);
    tbl_wr_en = 1'b1; tbl_wr_kind = 2'(kind); tbl_wr_dim = 6'(dim);
    tbl_wr_addr = 8'(addr); tbl_wr_data = 16'(data);
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic wr_feat(input int dim, input int data);
    feat_wr_en = 1'b1; feat_wr_dim = 6'(dim); feat_wr_data = 16'(data);
    @(negedge clk);
    feat_wr_en = 1'b0;
  endtask

  // offer one record at a falling edge and follow it for 21 edges
  task automatic send_comp(input longint w, input bit first, input bit last,
                           input longint exp, input string req, input bit stray);
    int bad = 0;
    comp_weight = 32'(w); comp_first = first; comp_last = last;
    for (int d = 0; d < D; d++) begin
      comp_mean_idx[d*MW +: MW] = 5'(mi[d]);
      comp_ivar_idx[d*VW +: VW] = 3'(vi[d]);
    end
    comp_valid = 1'b1;
    @(negedge clk);           // acceptance edge E0 has passed
    comp_valid = 1'b0;
    for (int k = 1; k <= 21; k++) begin
      if (stray && k == 2) begin
        comp_valid = 1'b1; comp_first = 1'b1; comp_last = 1'b1;
        comp_weight = 32'd77; comp_mean_idx = '1; comp_ivar_idx = '1;
      end
      if (stray && k == 12) comp_valid = 1'b0;
      @(negedge clk);
      if (k < 21 && (comp_ready || out_valid)) bad++;
    end
    check(bad == 0 && comp_ready, "R5", "ready low for 21 cycles", bad, 0);
    check(out_valid == last, "R9", "valid at edge 21", out_valid, last);
    if (last) check(longint'($signed(out_score)) == exp, req, "mixture score",
                    longint'($signed(out_score)), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    longint ca, cb, cc, acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(comp_ready == 1'b1, "R1", "ready after reset", comp_ready, 1);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    // R2: load everything through the write ports
    for (int d = 0; d < D; d++) t_feat[d] = d * 7 - 100;
    for (int d = 0; d < D; d++) begin
      for (int i = 0; i < 32; i++) t_mean[d][i] = mean_val(d, i);
      for (int j = 0; j < 8; j++)
        t_ivar[d][j] = (j == 7) ? 65535 : (j + 1) * ((d % 4) + 1) * 32;
    end
    for (int k = 0; k < 256; k++) t_corr[k] = (256 - k) * 40;
    for (int d = 0; d < D; d++) wr_feat(d, t_feat[d]);
    for (int d = 0; d < D; d++) begin
      for (int i = 0; i < 32; i++) wr_tbl(0, d, i, t_mean[d][i]);
      for (int j = 0; j < 8; j++) wr_tbl(1, d, j, t_ivar[d][j]);
    end
    for (int k = 0; k < 256; k++) wr_tbl(2, 0, k, t_corr[k]);

    // R3/R4: sweep every mean and inverse-variance entry, single-component mixtures
    for (int p = 0; p < 32; p++) begin
      longint w = 500000 - p * 7777;
      set_pattern(p);
      send_comp(w, 1'b1, 1'b1, model_comp(w), "R3 R4 sweep", 1'b0);
    end

    // R6/R7: two-component folds around the table edge, both orders
    begin
      int deltas [12] = '{0, 1, 100, 255, 256, 257, 5000, -1, -100, -255, -256, -300};
      foreach (deltas[n]) begin
        set_pattern(3);
        ca = model_comp(200000);
        cb = model_comp(200000 + deltas[n]);
        send_comp(200000, 1'b1, 1'b0, 0, "R6", 1'b0);
        send_comp(200000 + deltas[n], 1'b0, 1'b1, model_fold(ca, cb),
                  (deltas[n] > -256 && deltas[n] < 256) ? "R6 near fold" : "R7 far fold",
                  1'b0);
      end
    end

    // R6: fold saturates at the top of the range (zero cost pattern)
    for (int d = 0; d < D; d++) begin mi[d] = 0; vi[d] = d % 8; end
    send_comp(AMAX, 1'b1, 1'b0, 0, "R6", 1'b0);
    send_comp(AMAX, 1'b0, 1'b1, AMAX, "R6 saturated fold", 1'b0);

    // R6: three components folded one at a time
    set_pattern(1); ca = model_comp(90000);
    set_pattern(2); cb = model_comp(90100);
    set_pattern(4); cc = model_comp(89950);
    acc = model_fold(model_fold(ca, cb), cc);
    set_pattern(1); send_comp(90000, 1'b1, 1'b0, 0, "R6", 1'b0);
    set_pattern(2); send_comp(90100, 1'b0, 1'b0, 0, "R6", 1'b0);
    set_pattern(4); send_comp(89950, 1'b0, 1'b1, acc, "R6 three-way fold", 1'b0);

    // R8: a new first record discards the open partial total
    set_pattern(6); send_comp(1000000, 1'b1, 1'b0, 0, "R8", 1'b0);
    set_pattern(9); send_comp(300000, 1'b1, 1'b1, model_comp(300000), "R8 restart", 1'b0);

    // R10: valid held during the busy window is ignored
    set_pattern(11);
    ca = model_comp(400000);
    send_comp(400000, 1'b1, 1'b1, ca, "R10 busy input ignored", 1'b1);
    begin
      int extra = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (out_valid || !comp_ready) extra++;
      end
      check(extra == 0, "R10", "no extra record taken", extra, 0);
    end

    // R2: kind 3 writes nothing (mean entry 0 must still equal the feature)
    wr_tbl(3, 0, 0, 16'h1234);
    for (int d = 0; d < D; d++) begin mi[d] = 0; vi[d] = 7; end
    send_comp(12345, 1'b1, 1'b1, 12345, "R2 kind 3 ignored", 1'b0);

    // R3: one dimension cost exceeds the cap, the rest are zero
    t_feat[0] = 32767;
    wr_feat(0, 32767);
    for (int d = 0; d < D; d++) begin mi[d] = 0; vi[d] = 0; end
    for (int d = 1; d < D; d++) if (t_feat[d] == t_mean[d][0]) mi[d] = 0;
    mi[0] = 31; vi[0] = 7;
    send_comp(AMAX, 1'b1, 1'b1, model_comp(AMAX), "R3 per-dimension cap", 1'b0);
    check(model_comp(AMAX) == 0, "R3", "model cap value", model_comp(AMAX), 0);

    // R4: total cost drives the score to the floor
    mi[0] = 31; vi[0] = 7;
    for (int d = 1; d < D; d++) begin mi[d] = 20; vi[d] = 7; end
    send_comp(-2000000000, 1'b1, 1'b1, model_comp(-2000000000), "R4 floor", 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule